// File: doc/BRIEF.md
# Accumulator ALU with Carry Rotates and Flag File

This block is the arithmetic core of an 8-bit accumulator machine. Each cycle the surrounding datapath presents the accumulator value and a second operand. The second operand may come from a register, from memory or from an immediate. The datapath also presents a 3-bit operation code and one of two enables. The block works out the new accumulator value and a write strobe combinationally. It keeps the carry, zero, sign and parity flags in a small register that loads on the next clock edge.

With the operation enable, one of eight fixed operations runs. These are add, add with carry, subtract, subtract with borrow, AND, XOR, OR and compare. The accumulator is always the first operand. Compare only sets the flags. With the rotate enable, the accumulator turns by one bit, left or right, through the carry. The four flag values are also driven out as separate pins, so that a condition tester outside the block can use them directly.

Top module: `acc_alu`

## Requirements
- R1: Code 000 gives A+B and code 001 gives A+B+carry, both modulo 256. The carry flag takes the ninth bit of the sum.
- R2: Code 010 gives A-B and code 011 gives A-B-carry, modulo 256. The carry flag is set exactly when B, plus the carry for code 011, is larger than A as unsigned numbers.
- R3: Codes 100 (AND), 101 (XOR) and 110 (OR) write the bitwise result and clear the carry flag.
- R4: Code 111 (compare) sets the flags exactly as code 010 would. It holds acc_we low and drives acc_out equal to acc_in.
- R5: After every ALU operation, zero is set when the 8-bit result is 0. Sign copies result bit 7. Parity is 1 when the result has an even number of ones.
- R6: A left rotate (rot_en=1, rot_right=0) writes {A[6:0],A[7]} and loads the old A[7] into carry.
- R7: A right rotate (rot_en=1, rot_right=1) writes {A[0],A[7:1]} and loads the old A[0] into carry. Both rotates leave zero, sign and parity unchanged.
- R8: The flags change only on a clock edge where op_en or rot_en is high. With both low, the flags hold, acc_we is 0 and acc_out equals acc_in.
- R9: A synchronous active-high reset clears all four flags to 0.
- R10: When op_en and rot_en are both high, the ALU operation runs and the rotate request has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the flags |
| op_en | input | 1 | Run the ALU operation selected by op_code |
| op_code | input | 3 | Operation select, encoded as listed in R1 to R4 |
| rot_en | input | 1 | Rotate the accumulator through carry |
| rot_right | input | 1 | Rotate direction: 0 left, 1 right |
| acc_in | input | 8 | Current accumulator value |
| opnd_in | input | 8 | Second operand |
| acc_out | output | 8 | New accumulator value |
| acc_we | output | 1 | Accumulator write strobe |
| flag_c | output | 1 | Carry / borrow flag |
| flag_z | output | 1 | Zero flag |
| flag_s | output | 1 | Sign flag |
| flag_p | output | 1 | Even-parity flag |

## Verification
The assertions check several properties on every cycle: that compare never writes the accumulator, that the logic codes leave carry cleared, that rotates touch only carry and load it from the correct end, that the zero flag matches the previous result, and that idle cycles and reset hold or clear the flag file. The arithmetic values can only be shown by the bench's directed scenarios. These include sums and differences at the 8-bit wrap, borrow when A equals B and carry is set, and chains in which the stored carry feeds the next add-with-carry or subtract-with-borrow. The bench scenarios also cover parity over varied bit patterns and the priority of op_en over rot_en.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        OP_ADD = 3'b000,
        OP_ADC = 3'b001,
        OP_SUB = 3'b010,
        OP_SBB = 3'b011,
        OP_AND = 3'b100,
        OP_XOR = 3'b101,
        OP_OR  = 3'b110,
        OP_CMP = 3'b111
    } alu_op_e;

    typedef struct packed {
        logic p;
        logic s;
        logic z;
        logic c;
    } flag_t;

    function automatic logic uses_carry_in(input alu_op_e op);
        return (op == OP_ADC) || (op == OP_SBB);
    endfunction

    function automatic logic is_subtract(input alu_op_e op);
        return (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP);
    endfunction

    function automatic logic is_bitwise(input alu_op_e op);
        return (op == OP_AND) || (op == OP_XOR) || (op == OP_OR);
    endfunction

endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith
    import acc_alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           cin,
    output logic [W-1:0]   res,
    output logic           cout
);
    localparam int EW = W + 1;

    logic [EW-1:0] ext_a;
    logic [EW-1:0] ext_b;
    logic [EW-1:0] ext_c;
    logic [EW-1:0] total;

    assign ext_a = {1'b0, a};
    assign ext_b = {1'b0, b};
    assign ext_c = EW'(uses_carry_in(op) & cin);

    // One extended adder/subtractor: bit W is the carry on add and the borrow on subtract
    always_comb begin
        if (is_subtract(op)) begin
            total = ext_a - ext_b - ext_c;
        end else begin
            total = ext_a + ext_b + ext_c;
        end
        res  = total[W-1:0];
        cout = total[W];
    end

endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
    import acc_alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   res
);
    always_comb begin
        unique case (op)
            OP_AND:  res = a & b;
            OP_XOR:  res = a ^ b;
            OP_OR:   res = a | b;
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/acc_alu_rotate.sv
module acc_alu_rotate #(
    parameter int W = acc_alu_pkg::DATA_W
) (
    input  logic           right,
    input  logic [W-1:0]   a,
    output logic [W-1:0]   res,
    output logic           cout
);
    logic [W-1:0] rol_v;
    logic [W-1:0] ror_v;

    // The bit that leaves one end re-enters the other end
    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            assign rol_v[i] = a[(i + W - 1) % W];
            assign ror_v[i] = a[(i + 1) % W];
        end
    endgenerate

    assign res  = right ? ror_v : rol_v;
    assign cout = right ? a[0] : a[W-1];

endmodule

// File: rtl/acc_alu_flags.sv
module acc_alu_flags
    import acc_alu_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   upd_c,
    input  logic   upd_zsp,
    input  flag_t  nxt,
    output flag_t  q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            if (upd_c) begin
                q.c <= nxt.c;
            end
            if (upd_zsp) begin
                q.z <= nxt.z;
                q.s <= nxt.s;
                q.p <= nxt.p;
            end
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (q == '0)); // R9

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!upd_c && !upd_zsp) |=> $stable(q)); // R8

    AST_CARRY_ONLY_KEEPS_ZSP: assert property (@(posedge clk) disable iff (rst)
        (upd_c && !upd_zsp) |=> ($stable(q.z) && $stable(q.s) && $stable(q.p))); // R7

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          op_en,
    input  logic [2:0]    op_code,
    input  logic          rot_en,
    input  logic          rot_right,
    input  logic [W-1:0]  acc_in,
    input  logic [W-1:0]  opnd_in,
    output logic [W-1:0]  acc_out,
    output logic          acc_we,
    output logic          flag_c,
    output logic          flag_z,
    output logic          flag_s,
    output logic          flag_p
);
    alu_op_e      op;
    flag_t        flags_q;
    flag_t        flags_d;
    logic         upd_c;
    logic         upd_zsp;
    logic [W-1:0] ar_res;
    logic         ar_cout;
    logic [W-1:0] lg_res;
    logic [W-1:0] rot_res;
    logic         rot_cout;
    logic [W-1:0] alu_res;
    logic         alu_cy;

    assign op = alu_op_e'(op_code);

    acc_alu_arith #(.W(W)) u_arith (
        .op   (op),
        .a    (acc_in),
        .b    (opnd_in),
        .cin  (flags_q.c),
        .res  (ar_res),
        .cout (ar_cout)
    );

    acc_alu_logic #(.W(W)) u_logic (
        .op  (op),
        .a   (acc_in),
        .b   (opnd_in),
        .res (lg_res)
    );

    acc_alu_rotate #(.W(W)) u_rotate (
        .right (rot_right),
        .a     (acc_in),
        .res   (rot_res),
        .cout  (rot_cout)
    );

    assign alu_res = is_bitwise(op) ? lg_res : ar_res;
    assign alu_cy  = is_bitwise(op) ? 1'b0 : ar_cout;

    // op_en wins over rot_en; with neither high the accumulator passes through unwritten
    always_comb begin
        acc_out = acc_in;
        acc_we  = 1'b0;
        upd_c   = 1'b0;
        upd_zsp = 1'b0;
        flags_d = flags_q;
        if (op_en) begin
            upd_c     = 1'b1;
            upd_zsp   = 1'b1;
            flags_d.c = alu_cy;
            flags_d.z = (alu_res == '0);
            flags_d.s = alu_res[W-1];
            flags_d.p = ~^alu_res;
            if (op != OP_CMP) begin
                acc_out = alu_res;
                acc_we  = 1'b1;
            end
        end else if (rot_en) begin
            upd_c     = 1'b1;
            flags_d.c = rot_cout;
            acc_out   = rot_res;
            acc_we    = 1'b1;
        end
    end

    acc_alu_flags u_flags (
        .clk     (clk),
        .rst     (rst),
        .upd_c   (upd_c),
        .upd_zsp (upd_zsp),
        .nxt     (flags_d),
        .q       (flags_q)
    );

    assign flag_c = flags_q.c;
    assign flag_z = flags_q.z;
    assign flag_s = flags_q.s;
    assign flag_p = flags_q.p;

    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (op_en && op_code == 3'b111) |-> (!acc_we && acc_out == acc_in)); // R4

    AST_BITWISE_CLEARS_CARRY: assert property (@(posedge clk) disable iff (rst)
        (op_en && op_code[2] && op_code != 3'b111) |=> !flag_c); // R3

    AST_ZERO_TRACKS_RESULT: assert property (@(posedge clk) disable iff (rst)
        op_en |=> (flag_z == ($past(alu_res) == '0))); // R5

    AST_ROTL_CARRY: assert property (@(posedge clk) disable iff (rst)
        (rot_en && !op_en && !rot_right) |=> (flag_c == $past(acc_in[W-1]))); // R6

    AST_ROTR_CARRY: assert property (@(posedge clk) disable iff (rst)
        (rot_en && !op_en && rot_right) |=> (flag_c == $past(acc_in[0]))); // R7

    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!op_en && !rot_en) |-> (!acc_we && acc_out == acc_in)); // R8

endmodule

// File: tb/acc_alu_bench.sv
module acc_alu_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       op_en;
    logic [2:0] op_code;
    logic       rot_en;
    logic       rot_right;
    logic [7:0] acc_in;
    logic [7:0] opnd_in;
    logic [7:0] acc_out;
    logic       acc_we;
    logic       flag_c, flag_z, flag_s, flag_p;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model of the flag file, laid out {p,s,z,c}
    logic [3:0] mf;

    always #5 clk = ~clk;

    acc_alu u_acc_alu (
        .clk       (clk),
        .rst       (rst),
        .op_en     (op_en),
        .op_code   (op_code),
        .rot_en    (rot_en),
        .rot_right (rot_right),
        .acc_in    (acc_in),
        .opnd_in   (opnd_in),
        .acc_out   (acc_out),
        .acc_we    (acc_we),
        .flag_c    (flag_c),
        .flag_z    (flag_z),
        .flag_s    (flag_s),
        .flag_p    (flag_p)
    );

    function automatic logic even_ones(input logic [7:0] v);
        int n = 0;
        for (int i = 0; i < 8; i++) n += v[i];
        return (n % 2) == 0;
    endfunction

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, check the combinational outputs, clock, check flags
    task automatic step(input bit en, input logic [2:0] op, input logic [7:0] a,
                        input logic [7:0] b, input bit ren, input bit rdir, input string req);
        int         s;
        int         t;
        logic [7:0] r;
        logic       cy;
        logic [7:0] exp_acc;
        bit         exp_we;
        logic [3:0] nf;
        exp_acc = a;
        exp_we  = 1'b0;
        nf      = mf;
        r       = a;
        cy      = 1'b0;
        if (en) begin
            case (op)
                3'd0, 3'd1: begin
                    s  = int'(a) + int'(b) + ((op == 3'd1) ? int'(mf[0]) : 0);
                    r  = s[7:0];
                    cy = s > 255;
                end
                3'd2, 3'd3, 3'd7: begin
                    t  = int'(b) + ((op == 3'd3) ? int'(mf[0]) : 0);
                    s  = int'(a) - t + 512;
                    r  = s[7:0];
                    cy = t > int'(a);
                end
                3'd4: r = a & b;
                3'd5: r = a ^ b;
                default: r = a | b;
            endcase
            nf      = {even_ones(r), r[7], r == 8'd0, cy};
            exp_acc = (op == 3'd7) ? a : r;
            exp_we  = (op != 3'd7);
        end else if (ren) begin
            if (!rdir) begin
                exp_acc = {a[6:0], a[7]};
                nf[0]   = a[7];
            end else begin
                exp_acc = {a[0], a[7:1]};
                nf[0]   = a[0];
            end
            exp_we = 1'b1;
        end
        op_en     = en;
        op_code   = op;
        acc_in    = a;
        opnd_in   = b;
        rot_en    = ren;
        rot_right = rdir;
        #1;
        check(req, acc_out, exp_acc, "acc_out");
        check(req, acc_we, exp_we, "acc_we");
        @(posedge clk);
        #1;
        check(req, {flag_p, flag_s, flag_z, flag_c}, nf, "flags{p,s,z,c}");
        mf = nf;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        op_en = 1'b0; rot_en = 1'b0; rot_right = 1'b0;
        op_code = 3'd0; acc_in = 8'd0; opnd_in = 8'd0;
        repeat (2) @(posedge clk);
        #1;
        check("R9", {flag_p, flag_s, flag_z, flag_c}, 0, "flags after reset");
        mf = 4'd0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_add();
        step(1, 3'd0, 8'h12, 8'h34, 0, 0, "R1");  // plain add
        step(1, 3'd0, 8'h7F, 8'h01, 0, 0, "R1");  // sign from 7F+1
        step(1, 3'd0, 8'hFF, 8'h01, 0, 0, "R1");  // wrap to zero, carry out
        step(1, 3'd1, 8'h10, 8'h20, 0, 0, "R1");  // adc with carry=1
        step(1, 3'd1, 8'hF0, 8'h0F, 0, 0, "R1");  // adc, carry 0, result FF
        step(1, 3'd5, 8'h00, 8'h00, 0, 0, "R5");  // zero, parity even
    endtask

    task automatic t_sub();
        step(1, 3'd2, 8'h05, 8'h03, 0, 0, "R2");  // no borrow
        step(1, 3'd2, 8'h03, 8'h05, 0, 0, "R2");  // borrow set
        step(1, 3'd3, 8'h40, 8'h40, 0, 0, "R2");  // sbb with borrow-in, A==B -> borrow
        step(1, 3'd3, 8'h40, 8'h10, 0, 0, "R2");  // sbb with borrow-in
        step(1, 3'd3, 8'h00, 8'hFF, 0, 0, "R2");  // borrow from zero
    endtask

    task automatic t_logic();
        step(1, 3'd0, 8'hFF, 8'hFF, 0, 0, "R1");  // set carry first
        step(1, 3'd4, 8'hF0, 8'h3C, 0, 0, "R3");
        step(1, 3'd0, 8'h80, 8'h80, 0, 0, "R1");
        step(1, 3'd5, 8'hA5, 8'h0F, 0, 0, "R3");
        step(1, 3'd6, 8'h81, 8'h02, 0, 0, "R3");
        step(1, 3'd6, 8'h01, 8'h00, 0, 0, "R5");  // odd parity -> p=0
    endtask

    task automatic t_cmp();
        step(1, 3'd7, 8'h44, 8'h44, 0, 0, "R4");  // equal -> zero
        step(1, 3'd7, 8'h10, 8'h20, 0, 0, "R4");  // less -> borrow
        step(1, 3'd7, 8'hC8, 8'h08, 0, 0, "R4");  // greater, sign set
    endtask

    task automatic t_rotate();
        step(1, 3'd6, 8'h80, 8'h00, 0, 0, "R5");  // z=0 s=1 p=0 c=0 before rotates
        step(0, 3'd0, 8'h81, 8'h00, 1, 0, "R6");
        step(0, 3'd0, 8'h40, 8'h00, 1, 0, "R6");
        step(0, 3'd0, 8'h01, 8'h00, 1, 1, "R7");
        step(0, 3'd0, 8'h02, 8'h00, 1, 1, "R7");
        step(0, 3'd0, 8'h00, 8'h00, 1, 1, "R7");  // result 0 must not set zero
    endtask

    task automatic t_hold();
        step(1, 3'd2, 8'h00, 8'h01, 0, 0, "R2");  // all flags set c=1 s=1 p=1
        step(0, 3'd0, 8'h00, 8'hFF, 0, 0, "R8");
        step(0, 3'd3, 8'h55, 8'h55, 0, 1, "R8");
    endtask

    task automatic t_priority();
        step(1, 3'd4, 8'h0F, 8'hF0, 1, 0, "R10");
        step(1, 3'd0, 8'h81, 8'h01, 1, 1, "R10");
    endtask

    task automatic t_reset_mid();
        step(1, 3'd2, 8'h00, 8'h01, 0, 0, "R2");
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R9", {flag_p, flag_s, flag_z, flag_c}, 0, "flags after mid reset");
        mf = 4'd0;
        @(negedge clk);
        rst = 1'b0;
        step(1, 3'd1, 8'h01, 8'h01, 0, 0, "R9");  // adc sees cleared carry
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_add();
        t_sub();
        t_logic();
        t_cmp();
        t_rotate();
        t_hold();
        t_priority();
        t_reset_mid();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule